// File: doc/BRIEF.md
# Readback Configuration Scrubber Controller

This controller walks the configuration memory of a programmable device one frame at a time, in an endless loop. For every frame it reads each word back and compares it with the matching word of a known-good copy kept in a separate golden memory. If any word of the frame disagrees, the controller rewrites the entire frame from the golden copy. It then reads the frame a second time to confirm the repair. Three running counters report how many frames were scanned, how many were repaired successfully, and how many still mismatched after the repair.

When part of the device is about to be reprogrammed, scrubbing must stop. Otherwise the scrubber would overwrite the new contents with stale golden data. A host raises a pause request, and the controller stops at the next frame boundary and signals that it is idle. The host then changes the configuration memory and describes the changed region with a first-frame number and a frame count. When the host drops the pause request, the controller copies the new contents of that region into the golden memory before it scans any further frame.

Both memories share one frame/word address bus and have asynchronous reads: read data belongs to the address presented in the same cycle. A write takes effect on the next rising clock edge. The number of frames scanned before the address wraps is set at run time.

Top module: `scrub_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released: all three counters read zero, `pause_ack` is low, neither write enable is high, and scanning starts at frame 0.
- R2: The scan address advances by one frame and returns to frame 0 after frame `frame_count`-1. A `frame_count` of 0 behaves as 1. Frames at or above the count are never read or written. On leaving a pause, a stored scan address at or above the count restarts at frame 0.
- R3: A frame whose words all match the golden copy produces no write and adds one to `cnt_scanned`.
- R4: A mismatch in any word of a frame causes every one of that frame's `WPF` words to be written from the golden copy, one word per cycle at word indices 0 to `WPF`-1.
- R5: After a rewrite, the frame is read again. A clean reread adds one to `cnt_corrected`; a reread that still mismatches adds one to `cnt_uncorrectable`. In both cases `cnt_scanned` increases by one for that frame.
- R6: A raised `pause_req` takes effect only when the frame in progress finishes. The controller then asserts `pause_ack` and issues no writes until the request is dropped.
- R7: When `pause_req` drops with a nonzero `pr_len`, golden frames `pr_base` to `pr_base+pr_len`-1 are loaded from the configuration memory before scanning resumes. A `pr_len` of 0 loads nothing.
- R8: Each counter changes by at most one per cycle and holds its value while the controller is paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_count | input | FA_W+1 | Number of frames in the scan loop (0 treated as 1) |
| pause_req | input | 1 | Request to stop scrubbing at the next frame boundary |
| pr_base | input | FA_W | First frame of the reconfigured region |
| pr_len | input | FA_W+1 | Number of frames in the reconfigured region |
| mem_frame | output | FA_W | Frame address for both memories |
| mem_word | output | log2(WPF) | Word index within the frame |
| cfg_rd_en | output | 1 | Configuration memory read strobe |
| cfg_rdata | input | DW | Configuration memory read data for the current address |
| cfg_we | output | 1 | Configuration memory write enable |
| cfg_wdata | output | DW | Configuration memory write data |
| gold_rdata | input | DW | Golden memory read data for the current address |
| gold_we | output | 1 | Golden memory write enable |
| gold_wdata | output | DW | Golden memory write data |
| pause_ack | output | 1 | High while the controller is paused and idle |
| cnt_scanned | output | CNT_W | Frames whose check finished |
| cnt_corrected | output | CNT_W | Frames repaired and confirmed clean |
| cnt_uncorrectable | output | CNT_W | Frames still mismatching after repair |

## Verification
The bench places a persistent read fault in some frames. A controller that counted a repair without rereading the frame would report those frames as corrected instead of uncorrectable, and the faulty bit stays set on every read. It also sets the frame count to 0, to 1 and to the full memory, and plants errors just beyond the count. A wrong wrap would either skip the last frame or touch frames above the count. A pause is raised in the middle of a frame: acknowledging early would leave the frame unfinished and break the count of scanned frames. Reconfiguration rounds change region contents while paused. A controller that resumed before loading the golden region would undo the new contents and count false repairs.

// File: rtl/scrub_pkg.sv
// Shared types for the readback scrubber.
// Assumes nothing beyond the standard language.
package scrub_pkg;

    // Controller phases
    typedef enum logic [2:0] {
        ST_SCAN    = 3'd0,  // read back and compare the current frame
        ST_REPAIR  = 3'd1,  // rewrite the frame from the golden copy
        ST_VERIFY  = 3'd2,  // read back again to confirm the repair
        ST_PAUSED  = 3'd3,  // idle, acknowledging a pause request
        ST_REFRESH = 3'd4   // copy reconfigured frames into the golden copy
    } scrub_state_e;

endpackage

// File: rtl/scrub_word_cnt.sv
// Word index counter within a frame.
// Counts 0..WPF-1 while run is high and wraps to 0 after the last word.
// Assumes WPF >= 2 and that every active phase walks a whole frame.
module scrub_word_cnt #(
    parameter  int WPF  = 8,
    localparam int WA_W = $clog2(WPF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [WA_W-1:0] idx,
    output logic            last
);

    localparam logic [WA_W-1:0] LAST_IDX = WA_W'(WPF - 1);

    assign last = (idx == LAST_IDX);

    // Advance the word index, wrapping at the end of a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (run) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/scrub_frame_cmp.sv
// Frame mismatch accumulator.
// Compares one word pair per enabled cycle and reports, on the last word,
// whether any word of the frame differed. Clears itself after the last word.
// Assumes en stays high for all words of the frame being checked.
module scrub_frame_cmp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          last,
    input  logic [DW-1:0] rd_word,
    input  logic [DW-1:0] ref_word,
    output logic          frame_bad
);

    logic seen_bad;

    assign frame_bad = seen_bad | (en && (rd_word != ref_word));

    // Remember a mismatch until the frame ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_bad <= 1'b0;
        end else if (en) begin
            seen_bad <= last ? 1'b0 : frame_bad;
        end
    end

endmodule

// File: rtl/scrub_stats.sv
// Status counters: frames scanned, frames repaired, frames left bad.
// Each counter wraps modulo 2**CNT_W.
// Assumes at most one increment pulse per counter per cycle.
module scrub_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_scan,
    input  logic             inc_corr,
    input  logic             inc_unc,
    output logic [CNT_W-1:0] scanned,
    output logic [CNT_W-1:0] corrected,
    output logic [CNT_W-1:0] uncorrectable
);

    // Count finished frames and their outcomes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scanned       <= '0;
            corrected     <= '0;
            uncorrectable <= '0;
        end else begin
            if (inc_scan) scanned       <= scanned + 1'b1;
            if (inc_corr) corrected     <= corrected + 1'b1;
            if (inc_unc)  uncorrectable <= uncorrectable + 1'b1;
        end
    end

    // R8
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scanned == $past(scanned)) || (scanned == $past(scanned) + 1'b1));

    // R5
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((corrected != $past(corrected)) && (uncorrectable != $past(uncorrectable))));

    // R5
    outcome_scanned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((corrected != $past(corrected)) || (uncorrectable != $past(uncorrectable)))
        |-> (scanned != $past(scanned)));

endmodule

// File: rtl/scrub_ctrl.sv
// Readback configuration scrubber controller (top).
// Loops over configuration frames, compares each with a golden copy,
// rewrites and rechecks frames that differ, and supports a pause with a
// golden-copy reload for a reconfigured region.
// Assumes both memories read asynchronously at (mem_frame, mem_word) and
// write on the next rising edge; frame_count changes only while paused;
// pr_base + pr_len does not exceed 2**FA_W.
module scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int DW    = 32,
    parameter int FA_W  = 5,
    parameter int WPF   = 8,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FA_W:0]           frame_count,
    input  logic                    pause_req,
    input  logic [FA_W-1:0]         pr_base,
    input  logic [FA_W:0]           pr_len,
    output logic [FA_W-1:0]         mem_frame,
    output logic [$clog2(WPF)-1:0]  mem_word,
    output logic                    cfg_rd_en,
    input  logic [DW-1:0]           cfg_rdata,
    output logic                    cfg_we,
    output logic [DW-1:0]           cfg_wdata,
    input  logic [DW-1:0]           gold_rdata,
    output logic                    gold_we,
    output logic [DW-1:0]           gold_wdata,
    output logic                    pause_ack,
    output logic [CNT_W-1:0]        cnt_scanned,
    output logic [CNT_W-1:0]        cnt_corrected,
    output logic [CNT_W-1:0]        cnt_uncorrectable
);

    localparam int WA_W = $clog2(WPF);

    scrub_state_e      st;
    logic [FA_W-1:0]   scan_frame;
    logic [FA_W-1:0]   rf_frame;
    logic [FA_W:0]     rf_left;
    logic [WA_W-1:0]   word_idx;
    logic              word_last;
    logic              frame_bad;
    logic              cmp_en;
    logic [FA_W:0]     fc_eff;
    logic [FA_W-1:0]   scan_next;
    logic              frame_done;

    // Effective loop length, with zero treated as a single frame
    always_comb begin
        fc_eff = (frame_count == '0) ? {{FA_W{1'b0}}, 1'b1} : frame_count;
    end

    // Next scan address, wrapping at the loop length
    always_comb begin
        if (({1'b0, scan_frame} + 1'b1) >= fc_eff) scan_next = '0;
        else                                       scan_next = scan_frame + 1'b1;
    end

    assign cmp_en     = (st == ST_SCAN) || (st == ST_VERIFY);
    assign frame_done = word_last &&
                        (((st == ST_SCAN) && !frame_bad) || (st == ST_VERIFY));

    scrub_word_cnt #(.WPF(WPF)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st != ST_PAUSED),
        .idx   (word_idx),
        .last  (word_last)
    );

    scrub_frame_cmp #(.DW(DW)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cmp_en),
        .last      (word_last),
        .rd_word   (cfg_rdata),
        .ref_word  (gold_rdata),
        .frame_bad (frame_bad)
    );

    scrub_stats #(.CNT_W(CNT_W)) u_stats (
        .clk           (clk),
        .rst_n         (rst_n),
        .inc_scan      (frame_done),
        .inc_corr      ((st == ST_VERIFY) && word_last && !frame_bad),
        .inc_unc       ((st == ST_VERIFY) && word_last && frame_bad),
        .scanned       (cnt_scanned),
        .corrected     (cnt_corrected),
        .uncorrectable (cnt_uncorrectable)
    );

    // Phase sequencing, scan address and refresh bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_SCAN;
            scan_frame <= '0;
            rf_frame   <= '0;
            rf_left    <= '0;
        end else begin
            case (st)
                ST_SCAN: begin
                    if (word_last) begin
                        if (frame_bad) begin
                            st <= ST_REPAIR;
                        end else begin
                            scan_frame <= scan_next;
                            st         <= pause_req ? ST_PAUSED : ST_SCAN;
                        end
                    end
                end
                ST_REPAIR: begin
                    if (word_last) st <= ST_VERIFY;
                end
                ST_VERIFY: begin
                    if (word_last) begin
                        scan_frame <= scan_next;
                        st         <= pause_req ? ST_PAUSED : ST_SCAN;
                    end
                end
                ST_PAUSED: begin
                    if (!pause_req) begin
                        if ({1'b0, scan_frame} >= fc_eff) scan_frame <= '0;
                        if (pr_len != '0) begin
                            rf_frame <= pr_base;
                            rf_left  <= pr_len;
                            st       <= ST_REFRESH;
                        end else begin
                            st <= ST_SCAN;
                        end
                    end
                end
                ST_REFRESH: begin
                    if (word_last) begin
                        if (rf_left == {{FA_W{1'b0}}, 1'b1}) begin
                            st <= ST_SCAN;
                        end else begin
                            rf_frame <= rf_frame + 1'b1;
                            rf_left  <= rf_left - 1'b1;
                        end
                    end
                end
                default: st <= ST_SCAN;
            endcase
        end
    end

    // Memory-side address, strobes and write data
    always_comb begin
        mem_frame  = (st == ST_REFRESH) ? rf_frame : scan_frame;
        mem_word   = word_idx;
        cfg_rd_en  = (st == ST_SCAN) || (st == ST_VERIFY) || (st == ST_REFRESH);
        cfg_we     = (st == ST_REPAIR);
        cfg_wdata  = gold_rdata;
        gold_we    = (st == ST_REFRESH);
        gold_wdata = cfg_rdata;
        pause_ack  = (st == ST_PAUSED);
    end

    // R6
    paused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_ack |-> (!cfg_we && !gold_we));

    // R6
    ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_ack) |-> $past(pause_req));

    // R5
    reread_after_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_we) |-> (cfg_rd_en && (mem_frame == $past(mem_frame))));

    // R2
    scan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_SCAN) && ($past(st) == ST_SCAN) && $stable(frame_count))
        |-> ({1'b0, scan_frame} < fc_eff));

    // R8
    paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_ack && $past(pause_ack)) |-> $stable(cnt_scanned));

endmodule

// File: tb/test_scrub_ctrl.sv
// Bench for scrub_ctrl: memory models, directed corners, seeded random rounds.
module test_scrub_ctrl;

    localparam int DW  = 32;
    localparam int FAW = 5;
    localparam int WPF = 8;
    localparam int NF  = 1 << FAW;
    localparam int NW  = NF * WPF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [FAW:0]      frame_count = 6'd32;
    logic              pause_req = 1'b0;
    logic [FAW-1:0]    pr_base = '0;
    logic [FAW:0]      pr_len = '0;
    logic [FAW-1:0]    mem_frame;
    logic [2:0]        mem_word;
    logic              cfg_rd_en, cfg_we, gold_we, pause_ack;
    logic [DW-1:0]     cfg_rdata, cfg_wdata, gold_rdata, gold_wdata;
    logic [15:0]       cnt_scanned, cnt_corrected, cnt_uncorrectable;

    logic [DW-1:0] cfg_mem [NW];
    logic [DW-1:0] gold_mem[NW];
    logic [DW-1:0] flip    [NW];
    logic [DW-1:0] exp_cfg [NW];
    logic [DW-1:0] exp_gold[NW];

    logic          inj_en = 1'b0;
    logic          inj_gold = 1'b0;
    int            inj_idx = 0;
    logic [DW-1:0] inj_val = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr_cnt = 0;
    int gwr_cnt = 0;

    always #4 clk = ~clk;

    scrub_ctrl i_scrub_ctrl (
        .clk (clk), .rst_n (rst_n), .frame_count (frame_count),
        .pause_req (pause_req), .pr_base (pr_base), .pr_len (pr_len),
        .mem_frame (mem_frame), .mem_word (mem_word), .cfg_rd_en (cfg_rd_en),
        .cfg_rdata (cfg_rdata), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .gold_rdata (gold_rdata), .gold_we (gold_we), .gold_wdata (gold_wdata),
        .pause_ack (pause_ack), .cnt_scanned (cnt_scanned),
        .cnt_corrected (cnt_corrected), .cnt_uncorrectable (cnt_uncorrectable)
    );

    // Asynchronous reads; flip models a bit that reads wrong whatever is stored
    assign cfg_rdata  = cfg_mem[{mem_frame, mem_word}] ^ flip[{mem_frame, mem_word}];
    assign gold_rdata = gold_mem[{mem_frame, mem_word}];

    // Single writer for both memories: design writes plus bench pokes
    always @(posedge clk) begin
        if (cfg_we)  cfg_mem[{mem_frame, mem_word}]  <= cfg_wdata;
        if (gold_we) gold_mem[{mem_frame, mem_word}] <= gold_wdata;
        if (inj_en) begin
            if (inj_gold) gold_mem[inj_idx] <= inj_val;
            else          cfg_mem[inj_idx]  <= inj_val;
        end
        if (rst_n && cfg_we)  wr_cnt  <= wr_cnt + 1;
        if (rst_n && gold_we) gwr_cnt <= gwr_cnt + 1;
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One-cycle memory poke, called at a falling edge
    task automatic poke(input bit g, input int idx, input logic [DW-1:0] v);
        inj_en = 1'b1; inj_gold = g; inj_idx = idx; inj_val = v;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic flip_bit(input int idx);
        poke(1'b0, idx, cfg_mem[idx] ^ (32'd1 << $urandom_range(0, 31)));
    endtask

    task automatic wait_ack();
        while (!pause_ack) @(negedge clk);
    endtask

    // Predict one full loop, run it, pause, compare
    task automatic run_round(input int fcv, input int pb, input int pl);
        int fce = (fcv == 0) ? 1 : fcv;
        int nc = 0, nu = 0, nb = 0, mis_in = 0, mis_out = 0, mis_g = 0;
        logic [15:0] s0, c0, u0;
        int w0, g0;
        for (int i = 0; i < NW; i++) begin
            exp_gold[i] = gold_mem[i];
            exp_cfg[i]  = cfg_mem[i];
        end
        for (int f = pb; f < pb + pl; f++)
            for (int w = 0; w < WPF; w++) exp_gold[f*WPF+w] = cfg_mem[f*WPF+w] ^ flip[f*WPF+w];
        for (int f = 0; f < fce; f++) begin
            bit bad = 0, stuck = 0;
            for (int w = 0; w < WPF; w++) begin
                if ((cfg_mem[f*WPF+w] ^ flip[f*WPF+w]) != exp_gold[f*WPF+w]) bad = 1;
                if (flip[f*WPF+w] != '0) stuck = 1;
            end
            if (bad) begin
                nb++;
                if (stuck) nu++; else nc++;
                for (int w = 0; w < WPF; w++) exp_cfg[f*WPF+w] = exp_gold[f*WPF+w];
            end
        end
        frame_count = 6'(fcv); pr_base = 5'(pb); pr_len = 6'(pl);
        s0 = cnt_scanned; c0 = cnt_corrected; u0 = cnt_uncorrectable;
        w0 = wr_cnt; g0 = gwr_cnt;
        pause_req = 1'b0;
        @(negedge clk);
        while (int'(16'(cnt_scanned - s0)) < fce - 1) @(negedge clk);
        pause_req = 1'b1;
        wait_ack();
        chk(16'(cnt_scanned - s0) == 16'(fce), "R2 frames per loop", 16'(cnt_scanned - s0), fce);
        chk(16'(cnt_corrected - c0) == 16'(nc), "R5 corrected", 16'(cnt_corrected - c0), nc);
        chk(16'(cnt_uncorrectable - u0) == 16'(nu), "R5 uncorrectable", 16'(cnt_uncorrectable - u0), nu);
        chk(wr_cnt - w0 == nb * WPF, "R4 repair writes", wr_cnt - w0, nb * WPF);
        chk(gwr_cnt - g0 == pl * WPF, "R7 golden writes", gwr_cnt - g0, pl * WPF);
        for (int i = 0; i < NW; i++) begin
            if (cfg_mem[i] != exp_cfg[i]) begin
                if (i < fce * WPF) mis_in++; else mis_out++;
            end
            if (gold_mem[i] != exp_gold[i]) mis_g++;
        end
        chk(mis_in == 0, "R4 repaired contents", mis_in, 0);
        chk(mis_out == 0, "R2 frames above count untouched", mis_out, 0);
        chk(mis_g == 0, "R7 golden contents", mis_g, 0);
        pr_len = '0;
    endtask

    initial begin
        logic [15:0] s0;
        int w0;
        void'($urandom(32'd20240805));
        for (int i = 0; i < NW; i++) flip[i] = '0;
        @(negedge clk);
        for (int i = 0; i < NW; i++) begin
            logic [DW-1:0] v = $urandom;
            poke(1'b0, i, v);
            poke(1'b1, i, v);
        end
        @(negedge clk);
        chk(cnt_scanned == 0 && cnt_corrected == 0 && cnt_uncorrectable == 0,
            "R1 counters in reset", cnt_scanned, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnt_scanned == 0 && cnt_corrected == 0 && cnt_uncorrectable == 0,
            "R1 counters after reset", cnt_scanned, 0);
        chk(!pause_ack && !cfg_we && !gold_we, "R1 idle strobes", {pause_ack, cfg_we, gold_we}, 0);
        chk(mem_frame == 0, "R1 start frame", mem_frame, 0);

        // R3: first clean frame, then pause
        pause_req = 1'b1;
        wait_ack();
        chk(cnt_scanned == 1, "R3 clean frame scanned", cnt_scanned, 1);
        chk(wr_cnt == 0, "R3 no writes for clean frame", wr_cnt, 0);

        // R6: pause raised mid-frame is acknowledged only at frame end
        s0 = cnt_scanned;
        pause_req = 1'b0;
        repeat (3) @(negedge clk);
        pause_req = 1'b1;
        @(negedge clk);
        chk(!pause_ack, "R6 no ack mid-frame", pause_ack, 0);
        wait_ack();
        chk(16'(cnt_scanned - s0) == 1, "R6 frame finished before ack", 16'(cnt_scanned - s0), 1);

        // R6 R8: quiet and frozen while paused
        s0 = cnt_scanned; w0 = wr_cnt + gwr_cnt;
        repeat (20) @(negedge clk);
        chk(cnt_scanned == s0, "R8 counters hold while paused", cnt_scanned, s0);
        chk(wr_cnt + gwr_cnt == w0, "R6 no writes while paused", wr_cnt + gwr_cnt, w0);

        // R2: count of zero acts as one frame; frame 1 must stay broken
        flip_bit(0 * WPF + 3);
        flip_bit(1 * WPF + 5);
        run_round(0, 0, 0);
        poke(1'b0, 1 * WPF + 5, gold_mem[1 * WPF + 5]);

        // R2: full loop with errors in first and last frame
        flip_bit(0);
        flip_bit((NF - 1) * WPF + WPF - 1);
        run_round(NF, 0, 0);

        // R5: persistent read fault plus an ordinary error
        flip[4 * WPF + 2] = 32'h0000_0100;
        flip_bit(7 * WPF + 6);
        run_round(10, 0, 0);
        flip[4 * WPF + 2] = '0;

        // R7: reconfigure a region while paused
        for (int w = 0; w < 3 * WPF; w++) poke(1'b0, 12 * WPF + w, $urandom);
        run_round(NF, 12, 3);

        // Seeded random rounds
        for (int r = 0; r < 12; r++) begin
            int fcv = $urandom_range(0, NF);
            int fce = (fcv == 0) ? 1 : fcv;
            int pb = 0, pl = 0;
            for (int i = 0; i < NW; i++) flip[i] = '0;
            if (r % 3 == 2) begin
                pb = $urandom_range(0, NF - 1);
                pl = $urandom_range(1, (NF - pb) < 4 ? (NF - pb) : 4);
                for (int w = 0; w < pl * WPF; w++) poke(1'b0, pb * WPF + w, $urandom);
            end else if (r % 3 == 1) begin
                flip[$urandom_range(0, fce * WPF - 1)] = 32'd1 << $urandom_range(0, 31);
            end
            for (int e = $urandom_range(0, 4); e > 0; e--) flip_bit($urandom_range(0, fce * WPF - 1));
            if (fce < NF) flip_bit($urandom_range(fce * WPF, NW - 1));
            run_round(fcv, pb, pl);
            // restore any frames left broken above the count
            for (int i = 0; i < NW; i++)
                if (cfg_mem[i] != gold_mem[i]) poke(1'b0, i, gold_mem[i]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule